// File: doc/BRIEF.md
# No-turnaround pipelined synchronous SRAM

A synchronous static RAM of 18-bit words, split into two 9-bit lanes, with a registered read path and a delayed write-data path. A write command supplies its address on one edge and its data two advancing edges later, so read and write commands can follow one another on every cycle and the data bus never has to sit idle between them. Read data comes out of an output register on the edge after the command edge.

Commands are qualified by an active-low clock enable, a load/advance control and three chip selects (two active-low, one active-high). With load/advance high, the block continues the previous command as a four-beat wrapping burst, in linear or interleaved order. A pending write whose data arrives on the same edge as a read of its address is forwarded into the read result lane by lane. An asynchronous output enable and a two-edge sleep input silence the outputs; a low clock enable, or sleep, freezes the whole pipeline without losing state.

Top module: `pipe_sram`

## Requirements
- R1: While rst_ni is low and after its release, rvalid_o is 0 and rdata_o is 0 until a read is accepted.
- R2: On an advancing edge with load_ni low, sel_a_ni low, sel_b_i high and sel_c_ni low, a command is accepted; wr_ni high makes it a read whose word is on rdata_o, with rvalid_o high, after the next advancing edge.
- R3: For a write command (wr_ni low), wdata_i is sampled on the second advancing edge after the command edge and stored at the command's address.
- R4: lane_wr_ni[0] low enables bits 8:0 and lane_wr_ni[1] low enables bits 17:9 of a write; a lane whose strobe is high keeps its old contents.
- R5: A read whose array access falls on the data edge of a write to the same address returns the new data in the enabled lanes and the stored data in the others.
- R6: With load_ni high after an accepted command, the block issues beat k (k=1,2,3, wrapping to 0) at an address whose upper bits equal the start address and whose two low bits are start+k modulo 4 when interleave_i is low, or start XOR k when high; the direction is that of the loading command, wr_ni is ignored and lane_wr_ni is sampled per beat.
- R7: While clk_en_ni is high, all synchronous inputs are ignored, no command, write or burst step happens and the outputs hold.
- R8: load_ni low with any select inactive inserts a bubble: rvalid_o is low after the next advancing edge, load_ni high afterwards issues nothing, and writes already pending still complete.
- R9: While out_en_ni is high, rdata_o is 0 and rvalid_o is 0, independent of the clock.
- R10: sleep_i is sampled on every edge regardless of clk_en_ni; from the second edge after it is seen high the block is dormant (commands ignored, pipeline frozen, outputs 0), and it resumes two edges after sleep_i is seen low with its contents intact.
- R11: rvalid_o is high exactly when the output register holds read data, out_en_ni is low and the block is awake; otherwise rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Command address |
| clk_en_ni | input | 1 | Clock enable, active low |
| load_ni | input | 1 | Low: load new command; high: advance burst |
| wr_ni | input | 1 | Low: write, high: read |
| lane_wr_ni | input | 2 | Per-lane write strobes, active low |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| interleave_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | 18 | Write data, two cycles after its command |
| rdata_o | output | 18 | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The forwarding path and the array write collide when a write is followed at once by a read of the same address: the read's array access and the write's data capture land on the same edge. The bench provokes this directly with partial lane strobes and through random traffic on a small address space, and judges each output against a reference memory that applies the write before the read, so a wrong lane merge or a stale word shows as a data mismatch. Stalls and sleep are dropped into the middle of such pairs to confirm the pair survives the freeze.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/psr_cmd.sv
module psr_cmd
  import pipe_sram_pkg::*;
#(
  parameter int AW      = 6,
  parameter int BURST_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_ni,
  input  logic             sel_i,
  input  logic             wr_ni,
  input  logic             interleave_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] lane_wr_ni,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] lane_en_o
);
  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] cnt_q, cnt_n, lo_n;
  op_e                bop_q;

  assign cnt_n = cnt_q + 1'b1;
  assign lo_n  = interleave_i ? (base_q[BURST_W-1:0] ^ cnt_n)
                              : (base_q[BURST_W-1:0] + cnt_n);

  always_comb begin
    op_o      = OP_NONE;
    addr_o    = addr_i;
    lane_en_o = ~lane_wr_ni;
    if (!load_ni) begin
      if (sel_i) op_o = wr_ni ? OP_RD : OP_WR;
    end else if (bop_q != OP_NONE) begin
      op_o   = bop_q;
      addr_o = {base_q[AW-1:BURST_W], lo_n};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bop_q  <= OP_NONE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (adv_i) begin
      if (!load_ni) begin
        bop_q  <= sel_i ? (wr_ni ? OP_RD : OP_WR) : OP_NONE;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (bop_q != OP_NONE) begin
        cnt_q <= cnt_n;
      end
    end
  end
endmodule

// File: rtl/psr_array.sv
module psr_array
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lane_en_i[l]) lane_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = lane_q[raddr_i];
  end
endmodule

// File: rtl/psr_rdpath.sv
module psr_rdpath
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     raddr_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic              byp_i,
  input  logic [AW-1:0]     byp_addr_i,
  input  logic [LANES-1:0]  byp_lane_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  logic              hit;
  logic [DATA_W-1:0] merged;

  assign hit = byp_i && (byp_addr_i == raddr_i);

  // write whose data lands on this edge wins, lane by lane
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (hit && byp_lane_en_i[l])
      ? wdata_i[l*LANE_W +: LANE_W] : mem_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (adv_i) begin
      vld_o  <= rd_i;
      data_o <= rd_i ? merged : '0;
    end
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW      = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              clk_en_ni,
  input  logic              load_ni,
  input  logic              wr_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              interleave_i,
  input  logic              out_en_ni,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  typedef struct packed {
    op_e              op;
    logic [AW-1:0]    addr;
    logic [LANES-1:0] len;
  } cmd_t;

  logic [1:0]        slp_q;
  logic              dormant, adv, sel, c1_rd, c1_act, out_vld_q;
  cmd_t              cmd_n, c1_q, c2_q;
  logic [DATA_W-1:0] mem_rd, out_data_q;

  assign dormant = slp_q[1];
  assign adv     = !clk_en_ni && !dormant;
  assign sel     = !sel_a_ni && sel_b_i && !sel_c_ni;

  // sleep request is sampled on every edge, stall or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slp_q <= '0;
    else         slp_q <= {slp_q[0], sleep_i};
  end

  psr_cmd #(.AW(AW), .BURST_W(BURST_W)) u_cmd (
    .clk_i, .rst_ni, .adv_i(adv), .load_ni, .sel_i(sel), .wr_ni,
    .interleave_i, .addr_i, .lane_wr_ni,
    .op_o(cmd_n.op), .addr_o(cmd_n.addr), .lane_en_o(cmd_n.len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '{op: OP_NONE, addr: '0, len: '0};
      c2_q <= '{op: OP_NONE, addr: '0, len: '0};
    end else if (adv) begin
      c1_q <= cmd_n;
      c2_q <= c1_q;
    end
  end

  assign c1_rd  = (c1_q.op == OP_RD);
  assign c1_act = (c1_q.op != OP_NONE);

  psr_array #(.AW(AW)) u_array (
    .clk_i, .we_i(adv && c2_q.op == OP_WR), .waddr_i(c2_q.addr),
    .lane_en_i(c2_q.len), .wdata_i, .raddr_i(c1_q.addr), .rdata_o(mem_rd)
  );

  psr_rdpath #(.AW(AW)) u_rd (
    .clk_i, .rst_ni, .adv_i(adv), .rd_i(c1_rd), .raddr_i(c1_q.addr),
    .mem_i(mem_rd), .byp_i(c2_q.op == OP_WR), .byp_addr_i(c2_q.addr),
    .byp_lane_en_i(c2_q.len), .wdata_i, .vld_o(out_vld_q), .data_o(out_data_q)
  );

  assign rvalid_o = out_vld_q && !out_en_ni && !dormant;
  assign rdata_o  = rvalid_o ? out_data_q : '0;
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adv,
  input logic              load_ni,
  input logic              sel,
  input logic              c1_rd,
  input logic              c1_act,
  input logic              out_vld_q,
  input logic              clk_en_ni,
  input logic              out_en_ni,
  input logic              sleep_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);
  // R2
  rd_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && c1_rd) |=> out_vld_q);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> $stable(out_vld_q));

  // R8
  bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !load_ni && !sel) |=> !c1_act);

  // R9
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> (!rvalid_o && rdata_o == '0));

  // R10
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && $past(sleep_i)) |=> !rvalid_o);
endmodule

bind pipe_sram pipe_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adv(adv), .load_ni(load_ni), .sel(sel),
  .c1_rd(c1_rd), .c1_act(c1_act), .out_vld_q(out_vld_q),
  .clk_en_ni(clk_en_ni), .out_en_ni(out_en_ni), .sleep_i(sleep_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/tb_pipe_sram.sv
`timescale 1ns/1ps
module tb_pipe_sram;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic clk_en_n = 0, load_n = 0, wr_n = 1, sel_a_n = 1, sel_b = 0, sel_c_n = 1;
  logic [1:0] lane_n = 2'b11;
  logic ilv = 0, out_en_n = 0, sleep = 0;
  logic [17:0] wdata = '0, rdata;
  logic rvalid;

  int checks = 0, errors = 0;

  pipe_sram #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .clk_en_ni(clk_en_n),
    .load_ni(load_n), .wr_ni(wr_n), .lane_wr_ni(lane_n), .sel_a_ni(sel_a_n),
    .sel_b_i(sel_b), .sel_c_ni(sel_c_n), .interleave_i(ilv),
    .out_en_ni(out_en_n), .sleep_i(sleep), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  always #10 clk = ~clk;

  // reference model: ops 0 none, 1 read, 2 write
  logic [17:0]   mem_m [DEPTH];
  int            p1_op = 0, p2_op = 0, b_op = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0, b_base = '0;
  logic [1:0]    p1_l = '0, p2_l = '0, b_cnt = '0;
  logic          m_vld = 0, ms1 = 0, ms2 = 0;
  logic [17:0]   m_dat = '0;

  task automatic model_edge();
    bit sel_m;
    int n_op;
    logic [AW-1:0] n_a;
    logic [1:0] lo, nc;
    if (!clk_en_n && !ms2) begin
      if (p2_op == 2) begin
        if (p2_l[0]) mem_m[p2_a][8:0]  = wdata[8:0];
        if (p2_l[1]) mem_m[p2_a][17:9] = wdata[17:9];
      end
      m_vld = (p1_op == 1);
      m_dat = m_vld ? mem_m[p1_a] : '0;
      sel_m = !sel_a_n && sel_b && !sel_c_n;
      n_op = 0; n_a = addr;
      if (!load_n) begin
        if (sel_m) n_op = wr_n ? 1 : 2;
        b_op = n_op; b_base = addr; b_cnt = 0;
      end else if (b_op != 0) begin
        nc = b_cnt + 2'd1;
        lo = ilv ? (b_base[1:0] ^ nc) : (b_base[1:0] + nc);
        n_op = b_op; n_a = {b_base[AW-1:2], lo};
        b_cnt = nc;
      end
      p2_op = p1_op; p2_a = p1_a; p2_l = p1_l;
      p1_op = n_op;  p1_a = n_a;  p1_l = ~lane_n;
    end
    ms2 = ms1; ms1 = sleep;
  endtask

  task automatic compare(string tag);
    logic ev;
    logic [17:0] ed;
    ev = m_vld && !out_en_n && !ms2;
    ed = ev ? m_dat : '0;
    checks++;
    if (rvalid !== ev) begin
      errors++;
      $display("FAIL %s rvalid got %0b exp %0b", tag, rvalid, ev);
    end
    checks++;
    if (rdata !== ed) begin
      errors++;
      $display("FAIL %s rdata got %h exp %h", tag, rdata, ed);
    end
  endtask

  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  // drive one cycle of inputs; sel=0 deselects with a random inactive select
  task automatic drv(bit ld_n, bit sl, bit wn, logic [AW-1:0] a, logic [1:0] ln);
    int pick;
    load_n = ld_n; wr_n = wn; addr = a; lane_n = ln;
    wdata = 18'($urandom);
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    if (!sl) begin
      pick = $urandom_range(2);
      if (pick == 0) sel_a_n = 1;
      else if (pick == 1) sel_b = 0;
      else sel_c_n = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    compare("R1");
    rst_n = 1;
    drv(0, 0, 1, '0, 2'b11);
    step("R1");

    // R3 fill every word with back-to-back writes
    for (int a = 0; a < DEPTH; a++) begin
      drv(0, 1, 0, AW'(a), 2'b00);
      step("R3");
    end
    drv(0, 0, 1, '0, 2'b11); step("R3"); step("R3");

    // R2 alternating reads and writes, no idle cycle
    for (int i = 0; i < 24; i++) begin
      drv(0, 1, i[0], AW'($urandom), 2'b00);
      step("R2");
    end

    // R4 partial lane writes then reads
    drv(0, 1, 0, 6'd9, 2'b10); step("R4");
    drv(0, 1, 0, 6'd10, 2'b01); step("R4");
    drv(0, 1, 0, 6'd11, 2'b11); step("R4");
    drv(0, 0, 1, '0, 2'b11); step("R4");
    for (int a = 9; a < 12; a++) begin drv(0, 1, 1, AW'(a), 2'b11); step("R4"); end
    drv(0, 0, 1, '0, 2'b11); step("R4"); step("R4");

    // R5 write then immediate read of same address, each lane pattern
    for (int k = 0; k < 4; k++) begin
      drv(0, 1, 0, 6'd20, 2'(k)); step("R5");
      drv(0, 1, 1, 6'd20, 2'b11); step("R5");
      drv(0, 0, 1, '0, 2'b11);    step("R5"); step("R5");
    end

    // R6 bursts, linear and interleaved, read and write, wrap past four beats
    for (int m = 0; m < 2; m++) begin
      ilv = m[0];
      drv(0, 1, 1, 6'd37, 2'b11); step("R6");
      for (int b = 0; b < 5; b++) begin drv(1, 1, 0, '0, 2'b00); step("R6"); end
      drv(0, 1, 0, 6'd42, 2'b00); step("R6");
      for (int b = 0; b < 3; b++) begin drv(1, 0, 1, '0, 2'(b)); step("R6"); end
      drv(0, 1, 1, 6'd40, 2'b11); step("R6");
      for (int b = 0; b < 3; b++) begin drv(1, 1, 1, '0, 2'b11); step("R6"); end
    end

    // R7 stall in the middle of write/read traffic
    drv(0, 1, 0, 6'd3, 2'b00); step("R7");
    drv(0, 1, 1, 6'd3, 2'b11); step("R7");
    clk_en_n = 1;
    for (int i = 0; i < 4; i++) begin drv(0, 1, i[0], AW'($urandom), 2'b00); step("R7"); end
    clk_en_n = 0;
    drv(0, 1, 1, 6'd3, 2'b11); step("R7");
    drv(0, 0, 1, '0, 2'b11); step("R7"); step("R7");

    // R8 deselect bubble, then advance must stay idle; pending write still lands
    drv(0, 1, 0, 6'd50, 2'b00); step("R8");
    drv(0, 0, 1, '0, 2'b11);    step("R8");
    drv(1, 1, 1, '0, 2'b11);    step("R8");
    drv(1, 1, 0, '0, 2'b00);    step("R8");
    drv(0, 1, 1, 6'd50, 2'b11); step("R8");
    drv(0, 0, 1, '0, 2'b11);    step("R8"); step("R8");

    // R9 output enable high over a run of reads, checked between edges too
    for (int i = 0; i < 6; i++) begin
      drv(0, 1, 1, AW'(i), 2'b11);
      out_en_n = i[1];
      step("R9");
      out_en_n = ~out_en_n; #1 compare("R9");
    end
    out_en_n = 0;

    // R10 sleep over active traffic, contents kept
    drv(0, 1, 1, 6'd7, 2'b11); step("R10");
    sleep = 1;
    for (int i = 0; i < 5; i++) begin drv(0, 1, 0, AW'(i + 7), 2'b00); step("R10"); end
    sleep = 0;
    for (int i = 0; i < 5; i++) begin drv(0, 1, 1, AW'(i + 7), 2'b11); step("R10"); end

    // R11 constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(99);
      drv(($urandom_range(99) < 30) ? 1'b1 : 1'b0, $urandom_range(99) >= 10,
          1'($urandom), 6'($urandom_range(15)), 2'($urandom));
      clk_en_n = (r < 10);
      out_en_n = ($urandom_range(99) < 8);
      ilv = 1'($urandom);
      if ($urandom_range(99) < 2) sleep = ~sleep;
      step("R11");
    end
    sleep = 0; clk_en_n = 0; out_en_n = 0;
    drv(0, 0, 1, '0, 2'b11);
    repeat (4) step("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule